// File: doc/BRIEF.md
# Padded 2D Tile Load Address Generator

The block takes one two-dimensional load descriptor and expands it into an ordered stream of element reads towards external memory and element writes into an on-chip buffer. The tile in external memory is `y` rows of `x` elements. Consecutive rows sit `stride` elements apart, and that stride may exceed the row length. In the on-chip buffer the tile lands surrounded by an independent number of zero rows above and below and zero columns left and right. Every address counts elements, not bytes.

The buffer footprint, padding included, is written row-major and without gaps from the buffer base. A padding position produces a zero write flagged as fill and no memory read. A tile position produces a read request on a valid/ready handshake, and its buffer address is queued. When the in-order read response returns, the data is written to that queued address. A response always takes the write port, and a pending fill write waits one cycle. After the last write has been committed, `done_o` pulses for one cycle.

Top module: `pad_tile_loader`

## Requirements
- R1: After reset `busy_o`, `done_o`, `rd_req_valid_o` and `wr_en_o` are all 0. A `start_i` sampled while `busy_o` and `done_o` are both 0 captures the descriptor inputs. For a non-empty tile, `busy_o` is 1 in the following cycle.
- R2: A non-empty tile writes every buffer address from `sram_base_i` to `sram_base_i + (pad_top+y+pad_bottom)*(pad_left+x+pad_right) - 1` exactly once and writes no other address. Buffer position k holds footprint row k / W and column k % W, where W = pad_left+x+pad_right.
- R3: A footprint position whose row is outside `[pad_top, pad_top+y)` or whose column is outside `[pad_left, pad_left+x)` is written with data 0 and `wr_zero_o` = 1, and it issues no read request.
- R4: Read requests leave in row-major order. The element at tile row r and column c is requested at `dram_base_i + r*stride + c`, and each element is requested exactly once.
- R5: When the stride exceeds the row length, the addresses between the end of one row and the start of the next are never requested.
- R6: The n-th read response is written, with `wr_zero_o` = 0, to the buffer address of the n-th accepted request.
- R7: A response cycle always writes the response. A fill write due in that cycle is deferred, not dropped.
- R8: While `rd_req_valid_o` is 1 and `rd_req_ready_i` is 0, the request stays valid and its address stays unchanged in the next cycle.
- R9: `done_o` is a single-cycle pulse. It comes only after every footprint write has been committed and no request is pending. `busy_o` is 0 while it is high and afterwards.
- R10: With `y_size_i` or `x_size_i` equal to 0, `done_o` rises in the cycle after start, and there are no requests and no writes.
- R11: No more than `MAX_OUTST` reads are outstanding. Request generation stalls while that many are in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Descriptor valid, accepted when idle |
| dram_base_i | input | AW | Tile start in external memory (elements) |
| sram_base_i | input | SAW | Footprint start in buffer (elements) |
| y_size_i | input | CW | Tile rows |
| x_size_i | input | CW | Tile row length |
| stride_i | input | AW | Distance between tile rows in external memory |
| pad_top_i | input | PW | Zero rows above |
| pad_bottom_i | input | PW | Zero rows below |
| pad_left_i | input | PW | Zero columns left |
| pad_right_i | input | PW | Zero columns right |
| rd_req_valid_o | output | 1 | Read request valid |
| rd_req_ready_i | input | 1 | Read request accepted |
| rd_req_addr_o | output | AW | Read element address |
| rd_rsp_valid_i | input | 1 | In-order read response valid, always accepted |
| rd_rsp_data_i | input | DW | Read response data |
| wr_en_o | output | 1 | Buffer write strobe |
| wr_addr_o | output | SAW | Buffer write address |
| wr_data_o | output | DW | Buffer write data |
| wr_zero_o | output | 1 | Write is padding fill |
| busy_o | output | 1 | Descriptor in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A returning read response and a pending padding fill both want the single buffer write port in the same cycle. The bench provokes this by returning responses after random delays while the walk crosses padding columns between tile rows. Every write seen with a response present must carry the response data and no fill flag. After the descriptor completes, the full footprint image is compared with the expected one, so a fill that was dropped or written twice is caught. Random read-ready stalls run at the same time to check that stalled requests are held.

// File: rtl/pad_ld_pkg.sv
package pad_ld_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_RUN   = 2'd1,
    WALK_DRAIN = 2'd2,
    WALK_DONE  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/pad_ld_tag_fifo.sv
module pad_ld_tag_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           push_i,
  input  logic [W-1:0]   data_i,
  input  logic           pop_i,
  output logic [W-1:0]   data_o,
  output logic           full_o,
  output logic [$clog2(DEPTH):0] level_o
);
  localparam int PTR = $clog2(DEPTH);

  logic [PTR-1:0] wptr_q, rptr_q;
  logic [PTR:0]   level_q;
  logic [W-1:0]   slots [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [W-1:0] slot_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             slot_q <= '0;
      else if (push_i && wptr_q == PTR'(i))    slot_q <= data_i;
    end
    assign slots[i] = slot_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q  <= '0;
      rptr_q  <= '0;
      level_q <= '0;
    end else begin
      if (push_i) wptr_q <= wptr_q + 1'b1;
      if (pop_i)  rptr_q <= rptr_q + 1'b1;
      case ({push_i, pop_i})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
    end
  end

  assign data_o  = slots[rptr_q];
  assign full_o  = (level_q == (PTR+1)'(DEPTH));
  assign level_o = level_q;

  // R11
  fifo_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);
  // R6
  fifo_udf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (level_q != '0));
endmodule

// File: rtl/pad_ld_walk.sv
module pad_ld_walk
  import pad_ld_pkg::*;
#(
  parameter int AW  = 32,
  parameter int SAW = 16,
  parameter int CW  = 12,
  parameter int PW  = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [AW-1:0]  dram_base_i,
  input  logic [SAW-1:0] sram_base_i,
  input  logic [CW-1:0]  y_size_i,
  input  logic [CW-1:0]  x_size_i,
  input  logic [AW-1:0]  stride_i,
  input  logic [PW-1:0]  pad_top_i,
  input  logic [PW-1:0]  pad_bottom_i,
  input  logic [PW-1:0]  pad_left_i,
  input  logic [PW-1:0]  pad_right_i,
  input  logic           can_push_i,
  input  logic           req_ready_i,
  input  logic           pad_ok_i,
  input  logic           drained_i,
  output logic           req_valid_o,
  output logic [AW-1:0]  req_addr_o,
  output logic [SAW-1:0] slot_addr_o,
  output logic           pad_wr_o,
  output logic           busy_o,
  output logic           done_o
);
  localparam int TW = CW + 2;

  walk_st_e       st_q;
  logic [AW-1:0]  row_base_q, stride_q;
  logic [SAW-1:0] sptr_q;
  logic [CW-1:0]  ysz_q, xsz_q;
  logic [PW-1:0]  ptop_q, pleft_q;
  logic [TW-1:0]  rows_q, cols_q, row_q, col_q;

  logic data_row, data_col, in_data, step, last_col, last_row, empty_tile;

  assign empty_tile = (y_size_i == '0) || (x_size_i == '0);
  assign data_row = (row_q >= TW'(ptop_q)) && (row_q < TW'(ptop_q) + TW'(ysz_q));
  assign data_col = (col_q >= TW'(pleft_q)) && (col_q < TW'(pleft_q) + TW'(xsz_q));
  assign in_data  = data_row && data_col;

  assign req_valid_o = (st_q == WALK_RUN) && in_data && can_push_i;
  assign pad_wr_o    = (st_q == WALK_RUN) && !in_data && pad_ok_i;
  assign step        = (req_valid_o && req_ready_i) || pad_wr_o;
  assign last_col    = (col_q == cols_q - 1'b1);
  assign last_row    = (row_q == rows_q - 1'b1);

  assign req_addr_o  = row_base_q + AW'(col_q) - AW'(pleft_q);
  assign slot_addr_o = sptr_q;
  assign busy_o      = (st_q == WALK_RUN) || (st_q == WALK_DRAIN);
  assign done_o      = (st_q == WALK_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= WALK_IDLE;
      row_base_q <= '0;
      stride_q   <= '0;
      sptr_q     <= '0;
      ysz_q      <= '0;
      xsz_q      <= '0;
      ptop_q     <= '0;
      pleft_q    <= '0;
      rows_q     <= '0;
      cols_q     <= '0;
      row_q      <= '0;
      col_q      <= '0;
    end else begin
      unique case (st_q)
        WALK_IDLE: if (start_i) begin
          row_base_q <= dram_base_i;
          stride_q   <= stride_i;
          sptr_q     <= sram_base_i;
          ysz_q      <= y_size_i;
          xsz_q      <= x_size_i;
          ptop_q     <= pad_top_i;
          pleft_q    <= pad_left_i;
          rows_q     <= TW'(pad_top_i) + TW'(y_size_i) + TW'(pad_bottom_i);
          cols_q     <= TW'(pad_left_i) + TW'(x_size_i) + TW'(pad_right_i);
          row_q      <= '0;
          col_q      <= '0;
          st_q       <= empty_tile ? WALK_DONE : WALK_RUN;
        end
        WALK_RUN: if (step) begin
          sptr_q <= sptr_q + 1'b1;
          if (last_col) begin
            col_q <= '0;
            row_q <= row_q + 1'b1;
            if (data_row) row_base_q <= row_base_q + stride_q;
            if (last_row) st_q <= WALK_DRAIN;
          end else begin
            col_q <= col_q + 1'b1;
          end
        end
        WALK_DRAIN: if (drained_i) st_q <= WALK_DONE;
        default:    st_q <= WALK_IDLE;
      endcase
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));
  // R3
  pad_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_wr_o |-> !req_valid_o);
  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R10
  empty_fast_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == WALK_IDLE) && start_i && empty_tile |=> done_o && !busy_o);
endmodule

// File: rtl/pad_ld_wr_mux.sv
module pad_ld_wr_mux #(
  parameter int SAW = 16,
  parameter int DW  = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rsp_valid_i,
  input  logic [DW-1:0]  rsp_data_i,
  input  logic [SAW-1:0] rsp_addr_i,
  input  logic           pad_wr_i,
  input  logic [SAW-1:0] pad_addr_i,
  output logic           wr_en_o,
  output logic [SAW-1:0] wr_addr_o,
  output logic [DW-1:0]  wr_data_o,
  output logic           wr_zero_o
);
  // response owns the port; the walker holds fill writes off in that cycle
  always_comb begin
    wr_en_o   = rsp_valid_i || pad_wr_i;
    wr_zero_o = !rsp_valid_i && pad_wr_i;
    wr_addr_o = rsp_valid_i ? rsp_addr_i : pad_addr_i;
    wr_data_o = rsp_valid_i ? rsp_data_i : '0;
  end

  // R7
  pad_yield_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pad_wr_i |-> !rsp_valid_i);
endmodule

// File: rtl/pad_tile_loader.sv
module pad_tile_loader #(
  parameter int AW        = 32,
  parameter int SAW       = 16,
  parameter int CW        = 12,
  parameter int PW        = 4,
  parameter int DW        = 16,
  parameter int MAX_OUTST = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [AW-1:0]  dram_base_i,
  input  logic [SAW-1:0] sram_base_i,
  input  logic [CW-1:0]  y_size_i,
  input  logic [CW-1:0]  x_size_i,
  input  logic [AW-1:0]  stride_i,
  input  logic [PW-1:0]  pad_top_i,
  input  logic [PW-1:0]  pad_bottom_i,
  input  logic [PW-1:0]  pad_left_i,
  input  logic [PW-1:0]  pad_right_i,
  output logic           rd_req_valid_o,
  input  logic           rd_req_ready_i,
  output logic [AW-1:0]  rd_req_addr_o,
  input  logic           rd_rsp_valid_i,
  input  logic [DW-1:0]  rd_rsp_data_i,
  output logic           wr_en_o,
  output logic [SAW-1:0] wr_addr_o,
  output logic [DW-1:0]  wr_data_o,
  output logic           wr_zero_o,
  output logic           busy_o,
  output logic           done_o
);
  localparam int LVW = $clog2(MAX_OUTST) + 1;

  logic           fifo_full, req_fire, pad_wr, drained;
  logic [SAW-1:0] slot_addr, tag_head;
  logic [LVW-1:0] level;

  assign req_fire = rd_req_valid_o && rd_req_ready_i;
  assign drained  = (level == '0) || ((level == LVW'(1)) && rd_rsp_valid_i);

  pad_ld_walk #(.AW(AW), .SAW(SAW), .CW(CW), .PW(PW)) u_walk (
    .clk_i, .rst_ni, .start_i,
    .dram_base_i, .sram_base_i, .y_size_i, .x_size_i, .stride_i,
    .pad_top_i, .pad_bottom_i, .pad_left_i, .pad_right_i,
    .can_push_i  (!fifo_full),
    .req_ready_i (rd_req_ready_i),
    .pad_ok_i    (!rd_rsp_valid_i),
    .drained_i   (drained),
    .req_valid_o (rd_req_valid_o),
    .req_addr_o  (rd_req_addr_o),
    .slot_addr_o (slot_addr),
    .pad_wr_o    (pad_wr),
    .busy_o, .done_o
  );

  pad_ld_tag_fifo #(.W(SAW), .DEPTH(MAX_OUTST)) u_tags (
    .clk_i, .rst_ni,
    .push_i  (req_fire),
    .data_i  (slot_addr),
    .pop_i   (rd_rsp_valid_i),
    .data_o  (tag_head),
    .full_o  (fifo_full),
    .level_o (level)
  );

  pad_ld_wr_mux #(.SAW(SAW), .DW(DW)) u_wr (
    .clk_i, .rst_ni,
    .rsp_valid_i (rd_rsp_valid_i),
    .rsp_data_i  (rd_rsp_data_i),
    .rsp_addr_i  (tag_head),
    .pad_wr_i    (pad_wr),
    .pad_addr_i  (slot_addr),
    .wr_en_o, .wr_addr_o, .wr_data_o, .wr_zero_o
  );

  // R9
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !rd_req_valid_o && (level == '0));
  // R11
  outst_cap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level <= LVW'(MAX_OUTST));
endmodule

// File: tb/pad_tile_loader_tb.sv
module pad_tile_loader_tb;
  localparam int AW = 32, SAW = 16, CW = 12, PW = 4, DW = 16, OUTST = 4;
  localparam int SRAM_N = 4096;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic           start;
  logic [AW-1:0]  dbase, stride;
  logic [SAW-1:0] sbase;
  logic [CW-1:0]  ysz, xsz;
  logic [PW-1:0]  ptop, pbot, pleft, pright;
  logic           req_valid, req_ready, rsp_valid;
  logic [AW-1:0]  req_addr;
  logic [DW-1:0]  rsp_data, wr_data;
  logic           wr_en, wr_zero, busy, done;
  logic [SAW-1:0] wr_addr;

  pad_tile_loader #(.AW(AW), .SAW(SAW), .CW(CW), .PW(PW), .DW(DW), .MAX_OUTST(OUTST)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dram_base_i(dbase), .sram_base_i(sbase), .y_size_i(ysz), .x_size_i(xsz), .stride_i(stride),
    .pad_top_i(ptop), .pad_bottom_i(pbot), .pad_left_i(pleft), .pad_right_i(pright),
    .rd_req_valid_o(req_valid), .rd_req_ready_i(req_ready), .rd_req_addr_o(req_addr),
    .rd_rsp_valid_i(rsp_valid), .rd_rsp_data_i(rsp_data),
    .wr_en_o(wr_en), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_zero_o(wr_zero),
    .busy_o(busy), .done_o(done)
  );

  int checks = 0, fails = 0, cyc = 0;
  logic [AW-1:0] exp_req[$];
  logic [AW-1:0] mem_q[$];
  int            wcnt [SRAM_N];
  logic [DW-1:0] wval [SRAM_N];
  logic          wzro [SRAM_N];

  function automatic logic [DW-1:0] mem_val(logic [AW-1:0] a);
    return a[15:0] ^ 16'hA5C3;
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_case(int db, int sb, int ys, int xs, int st, int pt, int pb, int pl, int pr);
    int cols, fp, n, wtot, bad_cnt, bad_pad, bad_dat, done_at;
    bit hold, fin, rsp_drv;
    logic [AW-1:0] held;
    cols = pl + xs + pr;
    fp = (ys == 0 || xs == 0) ? 0 : (pt + ys + pb) * cols;
    exp_req.delete(); mem_q.delete();
    for (int r = 0; r < ys; r++)
      for (int c = 0; c < xs; c++) exp_req.push_back(AW'(db + r * st + c));
    for (int i = 0; i < SRAM_N; i++) begin wcnt[i] = 0; wval[i] = '0; wzro[i] = 0; end
    hold = 0; fin = 0; rsp_drv = 0; wtot = 0; n = 0; done_at = -1; held = '0;
    while (!fin && n < 20000) begin
      @(negedge clk);
      start = (n == 0);
      dbase = AW'(db); sbase = SAW'(sb); ysz = CW'(ys); xsz = CW'(xs); stride = AW'(st);
      ptop = PW'(pt); pbot = PW'(pb); pleft = PW'(pl); pright = PW'(pr);
      if (rsp_drv) void'(mem_q.pop_front());
      rsp_drv = (mem_q.size() > 0) && ($urandom % 3 != 0);
      rsp_valid = rsp_drv;
      rsp_data = rsp_drv ? mem_val(mem_q[0]) : '0;
      req_ready = ($urandom % 4 != 0);
      #5;
      if (n == 1 && fp > 0) chk(busy == 1'b1, "R1 busy after start", busy, 1);
      if (hold) chk(req_valid && req_addr == held, "R8 request held", req_addr, held);
      hold = req_valid && !req_ready; held = req_addr;
      if (req_valid && req_ready) begin
        if (exp_req.size() == 0) chk(0, "R4/R10 unexpected request", req_addr, 0);
        else begin
          chk(req_addr == exp_req[0], "R4/R5 request address", req_addr, exp_req[0]);
          void'(exp_req.pop_front());
        end
        mem_q.push_back(req_addr);
      end
      if (rsp_valid) begin
        chk(wr_en && !wr_zero && wr_data == rsp_data, "R7/R6 response owns write",
            {wr_en, wr_zero, wr_data}, {1'b1, 1'b0, rsp_data});
      end
      if (wr_en) begin
        wtot++;
        if (int'(wr_addr) >= sb && int'(wr_addr) < sb + fp && int'(wr_addr) < SRAM_N) begin
          wcnt[wr_addr]++; wval[wr_addr] = wr_data; wzro[wr_addr] = wr_zero;
        end else chk(0, "R2 write outside footprint", wr_addr, sb);
      end
      if (done) begin
        done_at = n; fin = 1;
        chk(wtot == fp && exp_req.size() == 0 && mem_q.size() == (rsp_drv ? 1 : 0) - (rsp_drv ? 1 : 0),
            "R9 all writes before done", wtot, fp);
        chk(!busy, "R9 busy low with done", busy, 0);
      end
      n++;
    end
    chk(fin, "R9 done seen", fin, 1);
    @(negedge clk); start = 0; rsp_valid = 0; #5;
    chk(!done && !busy, "R9 single done pulse", {done, busy}, 0);
    if (fp == 0) chk(done_at == 1 && wtot == 0, "R10 empty tile immediate done", done_at, 1);
    bad_cnt = 0; bad_pad = 0; bad_dat = 0;
    for (int k = 0; k < fp; k++) begin
      int rr, cc, a; bit dat;
      rr = k / cols; cc = k % cols; a = sb + k;
      dat = rr >= pt && rr < pt + ys && cc >= pl && cc < pl + xs;
      if (wcnt[a] != 1) bad_cnt++;
      else if (!dat && (wval[a] != 0 || !wzro[a])) bad_pad++;
      else if (dat && (wzro[a] || wval[a] != mem_val(AW'(db + (rr - pt) * st + (cc - pl))))) bad_dat++;
    end
    chk(bad_cnt == 0, "R2 each footprint slot written once", bad_cnt, 0);
    chk(bad_pad == 0, "R3 padding zero fill", bad_pad, 0);
    chk(bad_dat == 0, "R6 data placement", bad_dat, 0);
  endtask

  initial begin
    void'($urandom(32'd7411));
    start = 0; dbase = '0; sbase = '0; ysz = '0; xsz = '0; stride = '0;
    ptop = '0; pbot = '0; pleft = '0; pright = '0;
    req_ready = 0; rsp_valid = 0; rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #5;
    chk(!busy && !done && !req_valid && !wr_en, "R1 reset state", {busy, done, req_valid, wr_en}, 0);
    // R3 R2: 9x56 tile, top pad 1, side pads 1 -> 580 slots
    run_case(32'h0604_0000, 0, 9, 56, 56, 1, 0, 1, 1);
    // R5: stride 36 over 9-wide rows
    run_case(32'h0060_0d00, 18, 2, 9, 36, 0, 0, 0, 0);
    // R10: empty tiles
    run_case(100, 40, 0, 5, 8, 1, 1, 1, 1);
    run_case(100, 40, 3, 0, 8, 0, 2, 0, 0);
    // R7: heavy padding interleaved with responses
    run_case(500, 1000, 3, 2, 7, 2, 3, 3, 2);
    for (int i = 0; i < 12; i++) begin
      int xs;
      xs = $urandom % 6;
      run_case($urandom % 65536, $urandom % 2048, $urandom % 5, xs, xs + $urandom % 4,
               $urandom % 3, $urandom % 3, $urandom % 3, $urandom % 3);
    end
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule